// File: doc/BRIEF.md
# Two-Way Cache Miss Classifier

This block models the tag side of a small physically tagged cache. The cache has two ways per set and least-recently-used replacement. It accepts one physical byte address per cycle and returns, one cycle later, whether the reference hit. A miss also carries a cause. A miss is compulsory when the block was never referenced since reset. It is a capacity miss when a fully associative cache of the same size, fed the same stream, would also have missed. Every other miss is a conflict miss. No data is stored: the model keeps only tags, valid bits, replacement order and the bookkeeping that the cause needs.

A separate warm-up port installs blocks in a chosen order before traffic starts. Each installed block updates the real cache, the shadow cache and the record of referenced blocks exactly as a request would, but it produces no result. This lets the replacement order begin from a known state, for example with the eight blocks at byte addresses 0, 8, 16 … 56, where the last one installed is the most recent.

Top module: `cache_miss_sorter`

## Requirements
- R1: An address is split into a byte offset in bits 2:0, a set index in bits 4:3 and a tag in bits 13:5. Two addresses that differ only in the offset refer to the same block.
- R2: Each of the 4 sets holds 2 blocks. A miss fills an invalid way first (way 0 before way 1), otherwise the least recently used way, and the filled block becomes most recently used.
- R3: A request is accepted when req_valid and req_ready are both high. Exactly one cycle later res_valid is high with exactly one of res_hit and res_miss set. In every other cycle res_valid, res_hit and res_miss are low.
- R4: res_kind is 2'b00 on a hit, 2'b01 for a compulsory miss, 2'b10 for a capacity miss and 2'b11 for a conflict miss.
- R5: A miss is compulsory when its block (address bits 13:3) has not been referenced, by request or warm-up, since the last reset.
- R6: A non-compulsory miss is a capacity miss when an 8-entry fully associative LRU cache would also miss, and a conflict miss otherwise. The shadow cache sees every reference, hits included.
- R7: A warm-up write updates the cache, the shadow and the reference record in arrival order and gives no result. After the eight blocks at 0, 8 … 56 are warmed up, requests to them all hit.
- R8: While warm_valid is high, req_ready is low and no request is accepted.
- R9: Reset empties the cache and the shadow, clears the reference record and holds res_valid low.
- R10: Requests may be accepted on consecutive cycles, and each one is judged on the state left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| warm_valid | input | 1 | Install warm_addr this cycle |
| warm_addr | input | 14 | Byte address of the block to install |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 14 | Physical byte address of the request |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Request hit |
| res_miss | output | 1 | Request missed |
| res_kind | output | 2 | Hit or miss cause code |

## Verification
Warm-up and a request can arrive in the same cycle. Warm-up wins, and the request must wait without its address changing the state. The bench provokes this by raising both valids together. It judges the outcome by checking that req_ready is low, that no result follows, and that the retried request then gets the cause a reference model predicts from the state with the warm-up block included. Back-to-back requests to the same block are also judged, because the second one must see the state that the first one left behind.

// File: rtl/mcls_pkg.sv
`timescale 1ns/1ps
package mcls_pkg;
    typedef enum logic [1:0] {
        KIND_HIT  = 2'b00,
        KIND_COMP = 2'b01,
        KIND_CAP  = 2'b10,
        KIND_CONF = 2'b11
    } kind_e;

    typedef struct packed {
        logic  vld;
        logic  hit;
        logic  miss;
        kind_e kind;
    } result_t;
endpackage

// File: rtl/mcls_seen_map.sv
`timescale 1ns/1ps
module mcls_seen_map #(
    parameter int BLK_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [BLK_W-1:0] blk,
    output logic             seen
);
    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] bits_d, bits_q;

    assign seen = bits_q[blk];

    always_comb begin
        bits_d = bits_q;
        if (upd) bits_d[blk] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end
endmodule

// File: rtl/mcls_set_tags.sv
`timescale 1ns/1ps
module mcls_set_tags #(
    parameter int SET_W = 2,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [SET_W-1:0] set_idx,
    input  logic [TAG_W-1:0] tag_in,
    output logic             hit
);
    localparam int SETS = 1 << SET_W;

    typedef struct packed {
        logic [SETS-1:0][1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][1:0]            vld;
        logic [SETS-1:0]                 lru;  // index of least recently used way
    } tags_t;

    tags_t st_d, st_q;
    logic  hit0, hit1, vic;

    assign hit0 = st_q.vld[set_idx][0] && (st_q.tag[set_idx][0] == tag_in);
    assign hit1 = st_q.vld[set_idx][1] && (st_q.tag[set_idx][1] == tag_in);
    assign hit  = hit0 | hit1;

    always_comb begin
        st_d = st_q;
        if (!st_q.vld[set_idx][0])      vic = 1'b0;
        else if (!st_q.vld[set_idx][1]) vic = 1'b1;
        else                            vic = st_q.lru[set_idx];
        if (upd) begin
            if (hit) begin
                st_d.lru[set_idx] = hit0;
            end else begin
                st_d.tag[set_idx][vic] = tag_in;
                st_d.vld[set_idx][vic] = 1'b1;
                st_d.lru[set_idx]      = ~vic;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mcls_fa_shadow.sv
`timescale 1ns/1ps
module mcls_fa_shadow #(
    parameter int BLK_W = 11,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [BLK_W-1:0] blk,
    output logic             hit
);
    localparam int PW = $clog2(DEPTH);

    // Entry 0 is most recently used, entry DEPTH-1 least recently used.
    typedef struct packed {
        logic [DEPTH-1:0][BLK_W-1:0] blk;
        logic [DEPTH-1:0]            vld;
    } fa_t;

    fa_t              st_d, st_q;
    logic [DEPTH-1:0] hit_vec;
    logic [PW-1:0]    pos;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = st_q.vld[g] && (st_q.blk[g] == blk);
    end

    assign hit = |hit_vec;

    always_comb begin
        pos = PW'(DEPTH - 1);
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) pos = PW'(i);
        end
        st_d = st_q;
        if (upd) begin
            for (int i = 1; i < DEPTH; i++) begin
                if (i <= int'(pos)) begin
                    st_d.blk[i] = st_q.blk[i-1];
                    st_d.vld[i] = st_q.vld[i-1];
                end
            end
            st_d.blk[0] = blk;
            st_d.vld[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cache_miss_sorter.sv
`timescale 1ns/1ps
module cache_miss_sorter #(
    parameter int ADDR_W = 14,
    parameter int OFF_W  = 3,
    parameter int SET_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_valid,
    input  logic [ADDR_W-1:0] warm_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic [1:0]        res_kind
);
    import mcls_pkg::*;

    localparam int BLK_W    = ADDR_W - OFF_W;
    localparam int TAG_W    = BLK_W - SET_W;
    localparam int FA_DEPTH = (1 << SET_W) * 2;

    logic              req_fire, ref_fire;
    logic [ADDR_W-1:0] ref_addr;
    logic [BLK_W-1:0]  ref_blk;
    logic              real_hit, shadow_hit, seen;
    logic              unused_offset;
    result_t           r_d, r_q;

    assign req_ready     = !warm_valid;
    assign req_fire      = req_valid && req_ready;
    assign ref_fire      = warm_valid || req_fire;
    assign ref_addr      = warm_valid ? warm_addr : req_addr;
    assign ref_blk       = ref_addr[ADDR_W-1:OFF_W];
    assign unused_offset = ^ref_addr[OFF_W-1:0];

    mcls_set_tags #(.SET_W(SET_W), .TAG_W(TAG_W)) tags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (ref_fire),
        .set_idx (ref_blk[SET_W-1:0]),
        .tag_in  (ref_blk[BLK_W-1:SET_W]),
        .hit     (real_hit)
    );

    mcls_fa_shadow #(.BLK_W(BLK_W), .DEPTH(FA_DEPTH)) shadow_i (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (ref_fire),
        .blk   (ref_blk),
        .hit   (shadow_hit)
    );

    mcls_seen_map #(.BLK_W(BLK_W)) seen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (ref_fire),
        .blk   (ref_blk),
        .seen  (seen)
    );

    always_comb begin
        r_d      = '0;
        r_d.vld  = req_fire;
        r_d.hit  = req_fire && real_hit;
        r_d.miss = req_fire && !real_hit;
        if (!req_fire || real_hit) r_d.kind = KIND_HIT;
        else if (!seen)            r_d.kind = KIND_COMP;
        else if (!shadow_hit)      r_d.kind = KIND_CAP;
        else                       r_d.kind = KIND_CONF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_valid = r_q.vld;
    assign res_hit   = r_q.hit;
    assign res_miss  = r_q.miss;
    assign res_kind  = r_q.kind;
endmodule

// File: rtl/cache_miss_sorter_chk.sv
`timescale 1ns/1ps
module cache_miss_sorter_chk #(
    parameter int ADDR_W = 14,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              warm_valid,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              res_valid,
    input logic              res_hit,
    input logic              res_miss,
    input logic [1:0]        res_kind
);
    logic fire;
    assign fire = req_valid && req_ready;

    a_r3_one_cycle_result: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> res_valid);

    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_miss));

    a_r3_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_miss));

    a_r4_hit_code: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_kind == 2'b00));

    a_r4_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_kind != 2'b00));

    a_r8_warm_blocks_request: assert property (@(posedge clk) disable iff (!rst_n)
        warm_valid |=> !res_valid);

    a_r10_repeat_block_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && $past(fire) && (req_addr[ADDR_W-1:OFF_W] == $past(req_addr[ADDR_W-1:OFF_W])))
        |=> res_hit);
endmodule

bind cache_miss_sorter cache_miss_sorter_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_valid (warm_valid),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_miss   (res_miss),
    .res_kind   (res_kind)
);

// File: tb/cache_miss_sorter_tb_top.sv
`timescale 1ns/1ps
module cache_miss_sorter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_valid = 1'b0;
    logic [13:0] warm_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_addr = '0;
    logic        res_valid, res_hit, res_miss;
    logic [1:0]  res_kind;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cache_miss_sorter dut_i (
        .clk(clk), .rst_n(rst_n), .warm_valid(warm_valid), .warm_addr(warm_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_kind(res_kind)
    );

    // Reference model: timestamp LRU for sets and for the fully associative shadow.
    bit m_seen [2048];
    int m_tag  [4][2];
    bit m_val  [4][2];
    int m_age  [4][2];
    int m_fb   [8];
    bit m_fv   [8];
    int m_fage [8];
    int tick;
    int n_comp, n_cap, n_conf;

    bit    pend;
    int    pend_kind;
    string pend_req;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic m_clear();
        for (int i = 0; i < 2048; i++) m_seen[i] = 1'b0;
        for (int s = 0; s < 4; s++) for (int w = 0; w < 2; w++) begin
            m_val[s][w] = 1'b0; m_tag[s][w] = 0; m_age[s][w] = 0;
        end
        for (int i = 0; i < 8; i++) begin m_fv[i] = 1'b0; m_fb[i] = 0; m_fage[i] = 0; end
        tick = 0;
    endtask

    task automatic m_ref(input int blk, output int kind);
        int  s, t, w, v, fi, fv;
        bit  rh, fh;
        s = blk % 4; t = blk / 4; rh = 1'b0; fh = 1'b0; w = 0; fi = 0;
        for (int k = 0; k < 2; k++) if (m_val[s][k] && m_tag[s][k] == t) begin rh = 1'b1; w = k; end
        for (int k = 0; k < 8; k++) if (m_fv[k] && m_fb[k] == blk) begin fh = 1'b1; fi = k; end
        if (rh)               kind = 0;
        else if (!m_seen[blk]) kind = 1;
        else if (!fh)         kind = 2;
        else                  kind = 3;
        tick++;
        if (rh) m_age[s][w] = tick;
        else begin
            if (!m_val[s][0])      v = 0;
            else if (!m_val[s][1]) v = 1;
            else                   v = (m_age[s][0] < m_age[s][1]) ? 0 : 1;
            m_val[s][v] = 1'b1; m_tag[s][v] = t; m_age[s][v] = tick;
        end
        if (fh) m_fage[fi] = tick;
        else begin
            fv = -1;
            for (int k = 0; k < 8; k++) if (fv < 0 && !m_fv[k]) fv = k;
            if (fv < 0) begin
                fv = 0;
                for (int k = 1; k < 8; k++) if (m_fage[k] < m_fage[fv]) fv = k;
            end
            m_fv[fv] = 1'b1; m_fb[fv] = blk; m_fage[fv] = tick;
        end
        m_seen[blk] = 1'b1;
    endtask

    // Checks the result of the request accepted at the previous edge (R3, R4).
    task automatic check_pending();
        if (pend) begin
            chk(res_valid == 1'b1, pend_req, "res_valid", int'(res_valid), 1);
            chk(res_hit == (pend_kind == 0), pend_req, "res_hit", int'(res_hit), int'(pend_kind == 0));
            chk(res_miss == (pend_kind != 0), pend_req, "res_miss", int'(res_miss), int'(pend_kind != 0));
            chk(int'(res_kind) == pend_kind, pend_req, "res_kind", int'(res_kind), pend_kind);
            if (pend_kind == 1) n_comp++;
            if (pend_kind == 2) n_cap++;
            if (pend_kind == 3) n_conf++;
        end else begin
            chk(res_valid == 1'b0, "R3", "res_valid idle", int'(res_valid), 0);
        end
    endtask

    task automatic step(input bit wv, input int wa, input bit rv, input int ra, input string rq);
        int k;
        @(negedge clk);
        check_pending();
        warm_valid = wv; warm_addr = 14'(wa);
        req_valid  = rv; req_addr  = 14'(ra);
        pend = 1'b0;
        #1;
        if (wv) begin
            chk(req_ready == 1'b0, "R8", "req_ready during warm-up", int'(req_ready), 0);
            m_ref(wa / 8, k);
        end else begin
            chk(req_ready == 1'b1, "R8", "req_ready without warm-up", int'(req_ready), 1);
            if (rv) begin
                m_ref(ra / 8, k);
                pend = 1'b1; pend_kind = k; pend_req = rq;
            end
        end
    endtask

    task automatic idle();
        step(1'b0, 0, 1'b0, 0, "R3");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; warm_valid = 1'b0; req_valid = 1'b0; pend = 1'b0;
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R9", "res_valid in reset", int'(res_valid), 0);
        chk(req_ready == 1'b1, "R9", "req_ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        m_clear();
    endtask

    task automatic warm_up8();
        for (int b = 0; b < 8; b++) step(1'b1, b * 8, 1'b0, 0, "R7");
        idle();
    endtask

    logic [15:0] lfsr;

    initial begin
        pend = 1'b0; n_comp = 0; n_cap = 0; n_conf = 0;
        m_clear();
        do_reset();

        // R7: warm-up gives no result; all eight blocks then hit (R1: offsets vary, R10: back to back)
        warm_up8();
        for (int b = 0; b < 8; b++) step(1'b0, 0, 1'b1, b * 8 + b, "R7 R1 R10 warm hit");
        // R5: new block 8 (byte 64), set 0 replaces the LRU block 0
        step(1'b0, 0, 1'b1, 64, "R5 compulsory");
        // R6: block 0 evicted from shadow too -> capacity
        step(1'b0, 0, 1'b1, 0, "R6 capacity");
        // R2 + R6: block 4 (set 0) was evicted by block 0 from its set while shadow still holds it
        step(1'b0, 0, 1'b1, 32, "R2 R6 conflict");
        step(1'b0, 0, 1'b1, 64, "R2 R6 set-0 ping-pong");
        // R10: same block twice in a row, second hits
        step(1'b0, 0, 1'b1, 200, "R10 first");
        step(1'b0, 0, 1'b1, 203, "R10 repeat");
        idle();

        // R8: warm-up and request together; request must wait
        step(1'b1, 96, 1'b1, 96 + 32, "R8 blocked");
        step(1'b0, 0, 1'b1, 96 + 32, "R8 retried");
        step(1'b0, 0, 1'b1, 96, "R8 warm block hit");
        idle();

        // R2/R6 sweep over a small block range concentrated on few sets
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) step(1'b0, 0, 1'b1, (int'(lfsr[5:1]) % 20) * 32 + int'(lfsr[8:6]), "R2 R6 sweep");
            else         step(1'b0, 0, 1'b1, (int'(lfsr[6:1]) % 24) * 8 + int'(lfsr[9:7]), "R2 R6 sweep");
        end
        idle();

        // R5: exhaustive sweep of every block address
        for (int b = 0; b < 2048; b++) step(1'b0, 0, 1'b1, b * 8 + (b % 8), "R5 R1 full sweep");
        idle();

        // R9: reset clears the record; a previously seen block is compulsory again
        do_reset();
        step(1'b0, 0, 1'b1, 0, "R9 R5 after reset");
        step(1'b0, 0, 1'b1, 8 * 77, "R9 R5 after reset");
        idle();

        chk(n_comp > 0, "R5", "compulsory misses seen", n_comp, 1);
        chk(n_cap  > 0, "R6", "capacity misses seen", n_cap, 1);
        chk(n_conf > 0, "R6", "conflict misses seen", n_conf, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule